// File: doc/BRIEF.md
# Switch Legacy Interrupt Line Aggregator

This block tracks the four legacy interrupt lines (A, B, C, D) for a switch that has one upstream port and a parameterised number of downstream ports. Each downstream port receives assert and deassert messages from its link partner, one message per cycle across the whole switch. The block keeps a received state bit per line for each port. It combines that state with the port's own locally raised line-A interrupt, for example from a hot-plug controller. The result is a 4-bit status per downstream port, expressed in that port's own line numbering.

At the same time, the block rotates every downstream status onto upstream lines according to the port's device number. It ORs the rotated results into a switch-wide 4-bit status. Whenever a switch-wide line differs from what was last reported upstream, the block emits one assert or deassert message per cycle. When several lines differ at once, they are served from A to D. A downstream link that drops loses all of its received state, and the upstream view follows.

Top module: `intx_agg_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `port_status`, `up_status` and `up_msg_valid` are all zero.
- R2: A message with `msg_valid`=1 on port p for line x (`msg_line` 0=A, 1=B, 2=C, 3=D) sets received bit x of port p when `msg_assert`=1 and clears it when `msg_assert`=0. The new value appears on `port_status[4p+x]` one cycle after the message.
- R3: `port_status[4p+0]` is the OR of the received line-A bit and `local_inta[p]` (registered one cycle). Bits 1..3 of a port are not affected by `local_inta`.
- R4: The per-port status is not remapped. A message for line x on any port p shows at bit 4p+x, whatever p is.
- R5: `up_status[(x+p) mod 4]` is the OR over all downstream ports p and lines x of `port_status[4p+x]`, updated in the same cycle as `port_status`.
- R6: An upstream message (`up_msg_valid`=1, `up_msg_line`, `up_msg_assert`) is sent only when a switch-wide line differs from its last reported value. It is sent as an assert for a 0-to-1 change and as a deassert for a 1-to-0 change, one cycle after `up_status` changes if no other line is waiting. Repeated messages that change nothing produce no upstream message.
- R7: While `link_up[p]` is 0, all received state of port p is cleared, and this overrides a message to that port in the same cycle. One cycle later, port p's status shows only its local line A, and `up_status` follows.
- R8: At most one upstream message is sent per cycle. When several lines are waiting, the lowest-numbered line is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Received interrupt message strobe |
| msg_port | input | PW | Downstream port index of the message |
| msg_assert | input | 1 | 1 = assert, 0 = deassert |
| msg_line | input | 2 | Line index 0..3 (A..D) |
| local_inta | input | N_DS | Per-port locally generated line-A interrupt |
| link_up | input | N_DS | Per-port link status; 0 clears received state |
| port_status | output | 4*N_DS | Per-port unmapped aggregated lines, port p at bits 4p+3..4p |
| up_status | output | 4 | Switch-wide aggregate after rotation |
| up_msg_valid | output | 1 | Upstream message strobe |
| up_msg_assert | output | 1 | 1 = assert, 0 = deassert |
| up_msg_line | output | 2 | Upstream line of the message |

## Verification
Two functions can act in the same cycle: a link dropping, which clears a port's received state, and an incoming message to that same port or to another port. The bench provokes this by sending messages while a link is taken down. It then expects the clear to win on the dropped port and the message to take effect on the others. A link drop can change several switch-wide lines at once, so the upstream emitter then has to drain a backlog while fresh changes keep arriving. A cycle model in the bench, derived from the requirements, predicts each port status, the switch-wide status and every upstream message, including their order from A to D. This is followed by a pseudo-random walk over all inputs.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned NLINE = 4;
  typedef logic [NLINE-1:0] line_vec_t;

  // Rotate a port's line vector onto upstream lines by its device number.
  function automatic line_vec_t rotate_lines(input line_vec_t s, input int unsigned dev);
    line_vec_t r;
    r = '0;
    for (int x = 0; x < NLINE; x++) begin
      r[(x + dev) % NLINE] = s[x];
    end
    return r;
  endfunction
endpackage

// File: rtl/intx_port_state.sv
module intx_port_state
  import intx_pkg::*;
#(
  parameter int unsigned PORT_IDX = 0,
  parameter int unsigned PW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_up,
  input  logic          msg_valid,
  input  logic [PW-1:0] msg_port,
  input  logic          msg_assert,
  input  logic [1:0]    msg_line,
  input  logic          local_inta,
  output line_vec_t     status_d,
  output line_vec_t     status_q
);
  line_vec_t rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (!link_up) begin
      rx_d = '0;
    end else if (msg_valid && (msg_port == PW'(PORT_IDX))) begin
      rx_d[msg_line] = msg_assert;
    end
    status_d = rx_d | {{(NLINE-1){1'b0}}, local_inta};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q     <= '0;
      status_q <= '0;
    end else begin
      rx_q     <= rx_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/intx_up_map.sv
module intx_up_map
  import intx_pkg::*;
#(
  parameter int unsigned N_DS = 3
) (
  input  logic [N_DS*NLINE-1:0] status_d,
  output line_vec_t             up_d
);
  line_vec_t rot [N_DS];

  for (genvar p = 0; p < N_DS; p++) begin : g_rot
    assign rot[p] = rotate_lines(status_d[p*NLINE +: NLINE], p);
  end

  always_comb begin
    up_d = '0;
    for (int p = 0; p < N_DS; p++) begin
      up_d = up_d | rot[p];
    end
  end
endmodule

// File: rtl/intx_up_emitter.sv
module intx_up_emitter
  import intx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t up_d,
  output line_vec_t up_q,
  output logic      msg_valid,
  output logic      msg_assert,
  output logic [1:0] msg_line
);
  line_vec_t  sent_q;
  line_vec_t  pend;
  logic       found;
  logic [1:0] sel;

  always_comb begin
    pend  = up_q ^ sent_q;
    found = 1'b0;
    sel   = '0;
    for (int l = 0; l < NLINE; l++) begin
      if (!found && pend[l]) begin
        found = 1'b1;
        sel   = 2'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q       <= '0;
      sent_q     <= '0;
      msg_valid  <= 1'b0;
      msg_assert <= 1'b0;
      msg_line   <= '0;
    end else begin
      up_q       <= up_d;
      msg_valid  <= found;
      msg_line   <= sel;
      msg_assert <= up_q[sel];
      if (found) sent_q[sel] <= up_q[sel];
    end
  end
endmodule

// File: rtl/intx_agg_top.sv
module intx_agg_top
  import intx_pkg::*;
#(
  parameter int unsigned N_DS = 3,
  localparam int unsigned PW  = (N_DS > 1) ? $clog2(N_DS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  msg_valid,
  input  logic [PW-1:0]         msg_port,
  input  logic                  msg_assert,
  input  logic [1:0]            msg_line,
  input  logic [N_DS-1:0]       local_inta,
  input  logic [N_DS-1:0]       link_up,
  output logic [N_DS*NLINE-1:0] port_status,
  output logic [NLINE-1:0]      up_status,
  output logic                  up_msg_valid,
  output logic                  up_msg_assert,
  output logic [1:0]            up_msg_line
);
  logic [N_DS*NLINE-1:0] st_d;
  line_vec_t             up_d;

  for (genvar p = 0; p < N_DS; p++) begin : g_port
    intx_port_state #(.PORT_IDX(p), .PW(PW)) u_port (
      .clk        (clk),
      .rst        (rst),
      .link_up    (link_up[p]),
      .msg_valid  (msg_valid),
      .msg_port   (msg_port),
      .msg_assert (msg_assert),
      .msg_line   (msg_line),
      .local_inta (local_inta[p]),
      .status_d   (st_d[p*NLINE +: NLINE]),
      .status_q   (port_status[p*NLINE +: NLINE])
    );
  end

  intx_up_map #(.N_DS(N_DS)) u_map (
    .status_d (st_d),
    .up_d     (up_d)
  );

  intx_up_emitter u_emit (
    .clk        (clk),
    .rst        (rst),
    .up_d       (up_d),
    .up_q       (up_status),
    .msg_valid  (up_msg_valid),
    .msg_assert (up_msg_assert),
    .msg_line   (up_msg_line)
  );
endmodule

// File: rtl/intx_agg_chk.sv
module intx_agg_chk #(
  parameter int unsigned N_DS = 3,
  localparam int unsigned PW  = (N_DS > 1) ? $clog2(N_DS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic [PW-1:0]       msg_port,
  input logic                msg_assert,
  input logic [1:0]          msg_line,
  input logic [N_DS-1:0]     local_inta,
  input logic [N_DS-1:0]     link_up,
  input logic [N_DS*4-1:0]   port_status,
  input logic [3:0]          up_status,
  input logic                up_msg_valid,
  input logic                up_msg_assert,
  input logic [1:0]          up_msg_line
);
  logic [3:0] last_sent, prev_up, pend_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sent <= '0;
      prev_up   <= '0;
      pend_prev <= '0;
    end else begin
      prev_up   <= up_status;
      pend_prev <= up_status ^ (up_msg_valid ?
                   ((last_sent & ~(4'b1 << up_msg_line)) | (4'(up_msg_assert) << up_msg_line))
                   : last_sent);
      if (up_msg_valid) last_sent[up_msg_line] <= up_msg_assert;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (port_status == '0 && up_status == '0 && !up_msg_valid));

  // R5
  idle_up_chk: assert property (@(posedge clk) disable iff (rst)
    (port_status == '0) |-> (up_status == '0));

  // R6
  no_dup_msg_chk: assert property (@(posedge clk) disable iff (rst)
    up_msg_valid |-> (up_msg_assert != last_sent[up_msg_line]));

  // R6
  msg_follows_status_chk: assert property (@(posedge clk) disable iff (rst)
    up_msg_valid |-> (up_msg_assert == prev_up[up_msg_line]));

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    up_msg_valid |-> (pend_prev[up_msg_line] &&
                      ((pend_prev & ((4'b1 << up_msg_line) - 4'b1)) == 4'b0)));

  for (genvar p = 0; p < N_DS; p++) begin : g_link
    // R7
    linkdown_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !link_up[p] |=> (port_status[p*4 +: 4] == {3'b000, $past(local_inta[p])}));
  end
endmodule

bind intx_agg_top intx_agg_chk #(.N_DS(N_DS)) u_chk (.*);

// File: tb/tb_intx_agg_top.sv
module tb_intx_agg_top;
  localparam int N_DS = 3;
  localparam int PW = 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic msg_valid, msg_assert;
  logic [PW-1:0] msg_port;
  logic [1:0] msg_line;
  logic [N_DS-1:0] local_inta, link_up;
  logic [N_DS*4-1:0] port_status;
  logic [3:0] up_status;
  logic up_msg_valid, up_msg_assert;
  logic [1:0] up_msg_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_agg_top #(.N_DS(N_DS)) dut (.*);

  int errors = 0;
  int checks = 0;
  string ph;

  logic [3:0] rx_m [N_DS];
  logic [N_DS*4-1:0] ps_m;
  logic [3:0] us_m, sent_m;
  logic em_v, em_a;
  logic [1:0] em_l;
  int em_pend;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < N_DS; p++) rx_m[p] = '0;
    ps_m = '0; us_m = '0; sent_m = '0; em_v = 0; em_a = 0; em_l = 0; em_pend = 0;
  endtask

  task automatic model_step();
    logic [3:0] pend;
    pend = us_m ^ sent_m;
    em_pend = $countones(pend);
    em_v = 0;
    for (int l = 0; l < 4; l++) begin
      if (!em_v && pend[l]) begin
        em_v = 1; em_l = 2'(l); em_a = us_m[l]; sent_m[l] = us_m[l];
      end
    end
    for (int p = 0; p < N_DS; p++) begin
      if (!link_up[p]) rx_m[p] = '0;
      else if (msg_valid && msg_port == PW'(p)) rx_m[p][msg_line] = msg_assert;
      ps_m[p*4 +: 4] = rx_m[p] | {3'b000, local_inta[p]};
    end
    us_m = '0;
    for (int p = 0; p < N_DS; p++)
      for (int x = 0; x < 4; x++)
        if (ps_m[p*4+x]) us_m[(x+p)%4] = 1'b1;
  endtask

  task automatic compare();
    chk(ph, 32'(port_status), 32'(ps_m));
    chk("R5", 32'(up_status), 32'(us_m));
    chk(em_pend > 1 ? "R8" : "R6", {30'b0, up_msg_valid, em_v ? 1'b0 : 1'b0} >> 1, {31'b0, em_v});
    if (em_v) chk(em_pend > 1 ? "R8" : "R6", {30'b0, up_msg_assert, 1'b0} | 32'(up_msg_line),
                  {30'b0, em_a, 1'b0} | 32'(em_l));
  endtask

  task automatic tick(input logic v, input int p, input logic a, input int l);
    msg_valid = v; msg_port = PW'(p); msg_assert = a; msg_line = 2'(l);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst = 1; msg_valid = 0; msg_port = 0; msg_assert = 0; msg_line = 0;
    local_inta = '0; link_up = '1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(port_status), 0);
    chk("R1", 32'(up_status), 0);
    chk("R1", 32'(up_msg_valid), 0);
    rst = 0;
    ph = "R2";
    idle(1);
    // R2 / R6: sweep each port and line, with an absorbed repeat assert
    for (int p = 0; p < N_DS; p++)
      for (int x = 0; x < 4; x++) begin
        tick(1, p, 1, x);
        tick(1, p, 1, x);
        idle(1);
        tick(1, p, 0, x);
        tick(1, p, 0, x);
        idle(1);
      end
    // R4: same line held on all ports, read back unmapped
    ph = "R4";
    for (int x = 0; x < 4; x++) begin
      for (int p = 0; p < N_DS; p++) tick(1, p, 1, x);
      idle(2);
      for (int p = 0; p < N_DS; p++) tick(1, p, 0, x);
      idle(2);
    end
    // R3: local line A alone and overlapping a received line A
    ph = "R3";
    for (int p = 0; p < N_DS; p++) begin
      local_inta[p] = 1; idle(2);
      tick(1, p, 1, 0); idle(1);
      local_inta[p] = 0; idle(2);
      tick(1, p, 0, 0); idle(2);
    end
    // R7 / R8: several lines up, link drops while messages arrive
    ph = "R7";
    for (int x = 0; x < 4; x++) tick(1, 0, 1, x);
    tick(1, 1, 1, 2);
    idle(4);
    link_up[0] = 0;
    tick(1, 0, 1, 1);   // dropped port: clear wins
    tick(1, 1, 1, 3);   // other port: message takes effect
    link_up[0] = 1;
    idle(6);
    local_inta[2] = 1; link_up[1] = 0; idle(1);
    link_up[1] = 1; idle(6);
    local_inta = '0; idle(4);
    // Pseudo-random walk over all inputs
    ph = "R2";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      link_up = {|lf[8:7], |lf[10:9], |lf[12:11]};
      local_inta = {lf[13] & lf[0], lf[14] & lf[1], lf[15] & lf[2]};
      tick(lf[3] | lf[4], int'(lf[6:5]) % N_DS, lf[2], int'(lf[1:0]));
    end
    link_up = '1; local_inta = '0;
    idle(8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule